// File: doc/BRIEF.md
# Clock Root Command and Configuration Registers

This block is the register front end of one clock root generator. Software sees five 32-bit registers on a simple single-cycle bus: a command register, a configuration register holding the pre-divider, source select and counter mode, and three counter registers (M, N, D). Every write lands in a shadow copy. The settings that drive the clock datapath are held in a separate active copy, and that copy changes only when a commit is requested.

To commit, software sets the commit bit of the command register. The bit reads back as 1 while the transfer is pending. A fixed number of cycles later (two by default) the whole shadow set is copied into the active set in one edge, and the bit clears itself. Per-register dirty flags show which shadows have been written since the last commit.

The command register also holds a force-on bit. Together with the downstream branch request, it decides whether the root clock runs. A read-only root-off flag lets software poll that state.

Top module: `clk_root_regs`

## Requirements
- R1: After a synchronous reset, all shadow and active settings are 0, the commit bit and all dirty flags are 0, the force bit is 0, and the command register reads 0x8000_0000 (root off).
- R2: The configuration register at offset 0x4 stores the pre-divider in bits [4:0], the source select in bits [10:8] and the counter mode in bits [13:12]. A read returns only these fields and 0 elsewhere.
- R3: The M, N and D registers at offsets 0x8, 0xC and 0x10 each store bits [7:0] of the write data. A read returns those bits with 0 above.
- R4: A write to a shadow register leaves the active outputs unchanged until a commit is applied.
- R5: Writing the command register at offset 0x0 with bit 0 set starts a commit. Bit 0 reads 1 while it is pending. On the second clock edge after the write edge, the active outputs take the shadow values and bit 0 reads 0 again.
- R6: Command bits 4, 5, 6 and 7 are the dirty flags of config, N, M and D. Each is set by a write to its register and cleared when a commit is applied. A write in the same cycle as the apply leaves its flag set.
- R7: Command bit 1 is a read/write force-on control. The root_on output is registered and equals (force bit OR branch_req) one cycle later. Command bit 31 reads as the inverse of root_on.
- R8: Bit 31 of the command register ignores writes. Writing bit 0 as 0 has no effect. Offsets other than the five registers read 0 and ignore writes.
- R9: act_dual is 1 exactly when the active counter mode is 2 (dual-edge fractional operation).
- R10: Writing the commit bit while a commit is pending neither restarts nor extends the pending period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| branch_req | input | 1 | Downstream request for the root clock |
| root_on | output | 1 | Root clock running |
| act_src | output | SRC_W (3) | Active source select |
| act_div | output | DIV_W (5) | Active pre-divider |
| act_mode | output | 2 | Active counter mode |
| act_dual | output | 1 | Active mode is dual-edge |
| act_m | output | MND_W (8) | Active M value |
| act_n | output | MND_W (8) | Active N value |
| act_d | output | MND_W (8) | Active D value |

## Verification
A wrong pending counter shows up as a commit bit that reads 1 for the wrong number of cycles, and as active outputs that move on the wrong edge. Both are seen within three cycles of the command write. A wrong dirty or shadow state stays hidden until the next read or commit. The bench therefore reads every register after each phase and commits often, so such a fault reaches bus_rdata or the act_* outputs within a few cycles. The reference model is compared on every clock, so any divergence in root_on or the active set is reported on the cycle it appears.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;
  // Byte offsets of the registers
  localparam int OFS_CMD = 'h00;
  localparam int OFS_CFG = 'h04;
  localparam int OFS_M   = 'h08;
  localparam int OFS_N   = 'h0C;
  localparam int OFS_D   = 'h10;

  // Command register bit positions
  localparam int CMD_COMMIT_BIT = 0;
  localparam int CMD_FORCE_BIT  = 1;
  localparam int CMD_DIRTY_LSB  = 4;
  localparam int CMD_OFF_BIT    = 31;

  // Config register field positions
  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam logic [1:0] MODE_DUAL = 2'd2;

  // Dirty flag order; position = CMD_DIRTY_LSB + index
  typedef enum int {DI_CFG = 0, DI_N = 1, DI_M = 2, DI_D = 3} dirty_idx_e;

  // Counter register slots inside the block
  localparam int SLOT_M = 0;
  localparam int SLOT_N = 1;
  localparam int SLOT_D = 2;
  localparam int NUM_CNT = 3;
endpackage

// File: rtl/clk_root_shadow.sv
module clk_root_shadow
  import clk_root_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int SRC_W = 3,
  parameter int MND_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_cfg,
  input  logic [NUM_CNT-1:0]              wr_cnt,
  input  logic [DIV_W-1:0]                wd_div,
  input  logic [SRC_W-1:0]                wd_src,
  input  logic [1:0]                      wd_mode,
  input  logic [MND_W-1:0]                wd_cnt,
  input  logic                            apply,
  output logic [DIV_W-1:0]                sh_div,
  output logic [SRC_W-1:0]                sh_src,
  output logic [1:0]                      sh_mode,
  output logic [NUM_CNT-1:0][MND_W-1:0]   sh_cnt,
  output logic [3:0]                      dirty
);
  logic [3:0] dirty_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div  <= '0;
      sh_src  <= '0;
      sh_mode <= '0;
    end else if (wr_cfg) begin
      sh_div  <= wd_div;
      sh_src  <= wd_src;
      sh_mode <= wd_mode;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)            sh_cnt[g] <= '0;
      else if (wr_cnt[g]) sh_cnt[g] <= wd_cnt;
    end
  end

  always_comb begin
    dirty_set         = '0;
    dirty_set[DI_CFG] = wr_cfg;
    dirty_set[DI_M]   = wr_cnt[SLOT_M];
    dirty_set[DI_N]   = wr_cnt[SLOT_N];
    dirty_set[DI_D]   = wr_cnt[SLOT_D];
  end

  // a write in the apply cycle keeps its flag
  always_ff @(posedge clk) begin
    if (rst) dirty <= '0;
    else     dirty <= (apply ? 4'b0 : dirty) | dirty_set;
  end
endmodule

// File: rtl/clk_root_commit.sv
module clk_root_commit #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic pend,
  output logic apply
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  logic [CW-1:0] age;

  assign apply = pend && (age == CW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      age  <= '0;
    end else if (apply) begin
      pend <= 1'b0;
      age  <= '0;
    end else if (pend) begin
      age  <= age + 1'b1;
    end else if (req) begin
      pend <= 1'b1;
      age  <= '0;
    end
  end
endmodule

// File: rtl/clk_root_active.sv
module clk_root_active
  import clk_root_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int SRC_W = 3,
  parameter int MND_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          apply,
  input  logic [DIV_W-1:0]              sh_div,
  input  logic [SRC_W-1:0]              sh_src,
  input  logic [1:0]                    sh_mode,
  input  logic [NUM_CNT-1:0][MND_W-1:0] sh_cnt,
  output logic [DIV_W-1:0]              act_div,
  output logic [SRC_W-1:0]              act_src,
  output logic [1:0]                    act_mode,
  output logic                          act_dual,
  output logic [NUM_CNT-1:0][MND_W-1:0] act_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div  <= '0;
      act_src  <= '0;
      act_mode <= '0;
      act_dual <= 1'b0;
      act_cnt  <= '0;
    end else if (apply) begin
      act_div  <= sh_div;
      act_src  <= sh_src;
      act_mode <= sh_mode;
      act_dual <= (sh_mode == MODE_DUAL);
      act_cnt  <= sh_cnt;
    end
  end
endmodule

// File: rtl/clk_root_regs.sv
module clk_root_regs
  import clk_root_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DIV_W       = 5,
  parameter int SRC_W       = 3,
  parameter int MND_W       = 8,
  parameter int COMMIT_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              branch_req,
  output logic              root_on,
  output logic [SRC_W-1:0]  act_src,
  output logic [DIV_W-1:0]  act_div,
  output logic [1:0]        act_mode,
  output logic              act_dual,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(OFS_M);
  localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(OFS_N);
  localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(OFS_D);

  logic                          wr_cmd, wr_cfg;
  logic [NUM_CNT-1:0]            wr_cnt;
  logic                          force_q, commit_pend, commit_apply;
  logic [DIV_W-1:0]              sh_div;
  logic [SRC_W-1:0]              sh_src;
  logic [1:0]                    sh_mode;
  logic [NUM_CNT-1:0][MND_W-1:0] sh_cnt, act_cnt;
  logic [3:0]                    dirty;
  logic [31:0]                   rd_mux;

  // write decode
  assign wr_cmd         = bus_wr_en && (bus_addr == A_CMD);
  assign wr_cfg         = bus_wr_en && (bus_addr == A_CFG);
  assign wr_cnt[SLOT_M] = bus_wr_en && (bus_addr == A_M);
  assign wr_cnt[SLOT_N] = bus_wr_en && (bus_addr == A_N);
  assign wr_cnt[SLOT_D] = bus_wr_en && (bus_addr == A_D);

  clk_root_shadow #(.DIV_W(DIV_W), .SRC_W(SRC_W), .MND_W(MND_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .wr_cfg  (wr_cfg),
    .wr_cnt  (wr_cnt),
    .wd_div  (bus_wdata[DIV_W-1:0]),
    .wd_src  (bus_wdata[CFG_SRC_LSB +: SRC_W]),
    .wd_mode (bus_wdata[CFG_MODE_LSB +: 2]),
    .wd_cnt  (bus_wdata[MND_W-1:0]),
    .apply   (commit_apply),
    .sh_div  (sh_div),
    .sh_src  (sh_src),
    .sh_mode (sh_mode),
    .sh_cnt  (sh_cnt),
    .dirty   (dirty)
  );

  clk_root_commit #(.LAT(COMMIT_LAT)) u_commit (
    .clk   (clk),
    .rst   (rst),
    .req   (wr_cmd && bus_wdata[CMD_COMMIT_BIT]),
    .pend  (commit_pend),
    .apply (commit_apply)
  );

  clk_root_active #(.DIV_W(DIV_W), .SRC_W(SRC_W), .MND_W(MND_W)) u_active (
    .clk      (clk),
    .rst      (rst),
    .apply    (commit_apply),
    .sh_div   (sh_div),
    .sh_src   (sh_src),
    .sh_mode  (sh_mode),
    .sh_cnt   (sh_cnt),
    .act_div  (act_div),
    .act_src  (act_src),
    .act_mode (act_mode),
    .act_dual (act_dual),
    .act_cnt  (act_cnt)
  );

  assign act_m = act_cnt[SLOT_M];
  assign act_n = act_cnt[SLOT_N];
  assign act_d = act_cnt[SLOT_D];

  // force-on control and root state
  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= 1'b0;
      root_on <= 1'b0;
    end else begin
      if (wr_cmd) force_q <= bus_wdata[CMD_FORCE_BIT];
      root_on <= force_q | branch_req;
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CMD: begin
        rd_mux[CMD_COMMIT_BIT]            = commit_pend;
        rd_mux[CMD_FORCE_BIT]             = force_q;
        rd_mux[CMD_DIRTY_LSB +: 4]        = dirty;
        rd_mux[CMD_OFF_BIT]               = ~root_on;
      end
      A_CFG: begin
        rd_mux[DIV_W-1:0]                 = sh_div;
        rd_mux[CFG_SRC_LSB +: SRC_W]      = sh_src;
        rd_mux[CFG_MODE_LSB +: 2]         = sh_mode;
      end
      A_M:     rd_mux[MND_W-1:0] = sh_cnt[SLOT_M];
      A_N:     rd_mux[MND_W-1:0] = sh_cnt[SLOT_N];
      A_D:     rd_mux[MND_W-1:0] = sh_cnt[SLOT_D];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/clk_root_regs_chk.sv
module clk_root_regs_chk #(
  parameter int DIV_W = 5,
  parameter int SRC_W = 3,
  parameter int MND_W = 8,
  parameter int LAT   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr_en,
  input logic             pend,
  input logic [3:0]       dirty,
  input logic             force_q,
  input logic             branch_req,
  input logic             root_on,
  input logic [SRC_W-1:0] act_src,
  input logic [DIV_W-1:0] act_div,
  input logic [1:0]       act_mode,
  input logic             act_dual,
  input logic [MND_W-1:0] act_m,
  input logic [MND_W-1:0] act_n,
  input logic [MND_W-1:0] act_d
);
  int unsigned pend_age;

  always_ff @(posedge clk) begin
    if (rst)       pend_age <= 0;
    else if (pend) pend_age <= pend_age + 1;
    else           pend_age <= 0;
  end

  // R5: a pending commit never outlives its latency
  p_commit_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    pend |-> pend_age < LAT);

  // R4: active settings move only on the edge that ends a commit
  p_active_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_src, act_div, act_mode, act_m, act_n, act_d}) |-> $fell(pend));

  // R6: flags are clear after an apply with no concurrent write
  p_dirty_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(pend) && !$past(bus_wr_en)) |-> dirty == 4'b0);

  // R7: root state follows force or request one cycle later
  p_root_on_r7: assert property (@(posedge clk) disable iff (rst)
    (force_q || branch_req) |=> root_on);
  p_root_off_r7: assert property (@(posedge clk) disable iff (rst)
    !(force_q || branch_req) |=> !root_on);

  // R9: dual flag agrees with the active mode
  p_dual_mode_r9: assert property (@(posedge clk) disable iff (rst)
    act_dual == (act_mode == 2'd2));
endmodule

bind clk_root_regs clk_root_regs_chk #(
  .DIV_W(DIV_W), .SRC_W(SRC_W), .MND_W(MND_W), .LAT(COMMIT_LAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr_en  (bus_wr_en),
  .pend       (commit_pend),
  .dirty      (dirty),
  .force_q    (force_q),
  .branch_req (branch_req),
  .root_on    (root_on),
  .act_src    (act_src),
  .act_div    (act_div),
  .act_mode   (act_mode),
  .act_dual   (act_dual),
  .act_m      (act_m),
  .act_n      (act_n),
  .act_d      (act_d)
);

// File: tb/clk_root_regs_tb.sv
module clk_root_regs_tb;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, branch_req = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        root_on, act_dual;
  logic [2:0]  act_src;
  logic [4:0]  act_div;
  logic [1:0]  act_mode;
  logic [7:0]  act_m, act_n, act_d;

  clk_root_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .branch_req(branch_req), .root_on(root_on), .act_src(act_src),
    .act_div(act_div), .act_mode(act_mode), .act_dual(act_dual),
    .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  // reference state
  logic [4:0]  s_div, a_div;
  logic [2:0]  s_src, a_src;
  logic [1:0]  s_mode, a_mode;
  logic [7:0]  s_m, s_n, s_d, a_m, a_n, a_d;
  logic [3:0]  m_dirty;
  logic        m_pend, m_force, m_on;
  int          m_age;
  logic [31:0] m_rdata;
  int          vecs = 0, errs = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] ref_read(input logic [4:0] a);
    case (a)
      5'h00: return {~m_on, 23'd0, m_dirty[3], m_dirty[2], m_dirty[1], m_dirty[0], 2'b00, m_force, m_pend};
      5'h04: return {18'd0, s_mode, 1'b0, s_src, 3'd0, s_div};
      5'h08: return {24'd0, s_m};
      5'h0C: return {24'd0, s_n};
      5'h10: return {24'd0, s_d};
      default: return 32'd0;
    endcase
  endfunction

  task automatic ref_step();
    logic [31:0] rd;
    bit          apply;
    if (rst) begin
      s_div = 0; s_src = 0; s_mode = 0; s_m = 0; s_n = 0; s_d = 0;
      a_div = 0; a_src = 0; a_mode = 0; a_m = 0; a_n = 0; a_d = 0;
      m_dirty = 0; m_pend = 0; m_force = 0; m_on = 0; m_age = 0; m_rdata = 0;
      return;
    end
    rd    = ref_read(addr);
    apply = m_pend && (m_age == LAT - 1);
    m_on  = m_force | branch_req;
    if (apply) begin
      a_div = s_div; a_src = s_src; a_mode = s_mode;
      a_m = s_m; a_n = s_n; a_d = s_d;
      m_dirty = 0; m_pend = 0; m_age = 0;
    end else if (m_pend) begin
      m_age++;
    end else if (wr_en && addr == 5'h00 && wdata[0]) begin
      m_pend = 1; m_age = 0;
    end
    if (wr_en) begin
      case (addr)
        5'h00: m_force = wdata[1];
        5'h04: begin s_div = wdata[4:0]; s_src = wdata[10:8]; s_mode = wdata[13:12]; m_dirty[0] = 1; end
        5'h0C: begin s_n = wdata[7:0]; m_dirty[1] = 1; end
        5'h08: begin s_m = wdata[7:0]; m_dirty[2] = 1; end
        5'h10: begin s_d = wdata[7:0]; m_dirty[3] = 1; end
        default: ;
      endcase
    end
    if (rd_en) m_rdata = rd;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  string rtag;
  task automatic compare_all();
    check("R4 R5 act_src", 32'(act_src), 32'(a_src));
    check("R4 R5 act_div", 32'(act_div), 32'(a_div));
    check("R4 R5 act_mode", 32'(act_mode), 32'(a_mode));
    check("R9 act_dual", 32'(act_dual), 32'(a_mode == 2'd2));
    check("R4 R5 act_m", 32'(act_m), 32'(a_m));
    check("R4 R5 act_n", 32'(act_n), 32'(a_n));
    check("R4 R5 act_d", 32'(act_d), 32'(a_d));
    check("R7 root_on", 32'(root_on), 32'(m_on));
    check(rtag, rdata, m_rdata);
  endtask

  task automatic cyc(input logic we, input logic re, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    if (re)
      case (a)
        5'h00: rtag = "R5 R6 R7 R8 cmd read";
        5'h04: rtag = "R2 cfg read";
        5'h08, 5'h0C, 5'h10: rtag = "R3 counter read";
        default: rtag = "R8 unmapped read";
      endcase
    @(posedge clk);
    #1;
    ref_step();
    compare_all();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input logic [4:0] a);                       cyc(0, 1, a, 0); endtask
  task automatic idle();                                        cyc(0, 0, 0, 0); endtask
  task automatic read_all();
    rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10);
  endtask

  initial begin
    rtag = "R8 rdata";
    repeat (3) cyc(0, 0, 0, 0);
    @(negedge clk); rst = 1'b0;
    // R1: reset state seen at the ports
    rd(5'h00);
    idle();
    check("R1 cmd after reset", rdata, 32'h8000_0000);
    check("R1 act after reset", {act_m, act_n, act_d, act_div, act_src, act_mode}, 32'd0);
    read_all();

    // R2 R3 R4 R6: shadow writes with junk in unused bits
    wr(5'h04, 32'hFFFF_E4F3);
    wr(5'h08, 32'hABCD_0003);
    wr(5'h0C, 32'h1234_56FA);
    wr(5'h10, 32'h0000_11F7);
    read_all();
    repeat (2) idle();

    // R5: commit, poll each cycle
    wr(5'h00, 32'h0000_0001);
    rd(5'h00); rd(5'h00); rd(5'h00);
    read_all();

    // R7: force on, then clear; bit 31 written 1 is ignored (R8)
    wr(5'h00, 32'h0000_0002);
    rd(5'h00); rd(5'h00);
    wr(5'h00, 32'h8000_0000);
    rd(5'h00); rd(5'h00);
    branch_req = 1'b1; rd(5'h00); rd(5'h00);
    branch_req = 1'b0; rd(5'h00); rd(5'h00);

    // R8: commit bit written 0 does nothing; unmapped offsets
    wr(5'h04, 32'h0000_1207);
    wr(5'h00, 32'h0000_0000);
    rd(5'h00); rd(5'h00);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h14); rd(5'h1C); rd(5'h02); rd(5'h06);
    read_all();

    // R10: re-request while pending; R6: write lands in apply cycle
    wr(5'h00, 32'h0000_0001);
    wr(5'h00, 32'h0000_0003);
    wr(5'h08, 32'h0000_0055);
    rd(5'h00); rd(5'h00);
    read_all();

    // R9: mode 2 then mode 3 commits
    wr(5'h04, 32'h0000_2000);
    wr(5'h00, 32'h0000_0001);
    repeat (3) idle();
    wr(5'h04, 32'h0000_371F);
    wr(5'h0C, 32'h0000_0000);
    wr(5'h00, 32'h0000_0001);
    rd(5'h00); rd(5'h00); rd(5'h00);
    read_all();

    // reset mid-pending returns to R1 state
    wr(5'h00, 32'h0000_0003);
    @(negedge clk); rst = 1'b1;
    idle();
    @(negedge clk); rst = 1'b0;
    rd(5'h00);
    idle();
    check("R1 cmd after second reset", rdata, 32'h8000_0000);
    read_all();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule